// File: doc/BRIEF.md
# Byte ALU with Rotates, Shifts and Zero/One Compares

This unit performs one arithmetic, logic, shift, rotate or compare operation per clock on two operand bytes. The operation is chosen directly by an 8-bit opcode. The unit decodes that opcode itself and registers the result. Alongside the result it reports three things: whether the opcode names an operation of this unit, whether the answer belongs in the accumulator or the general return register, and whether a divide or modulo met a zero divisor.

The unit has no flags. Compares give a byte of value 01h or 00h. Shift and rotate amounts are variable and are taken from the second operand. Division by zero does not trap. It returns an all-ones byte and raises a one-cycle indication alongside it.

Top module: `byte_alu`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it rises, `out_valid`, `result`, `to_acc`, `op_known` and `div_zero` are all zero.
- R2: A request accepted with `in_valid` high appears on the outputs one clock later with `out_valid` high. A cycle without `in_valid` drops `out_valid` and leaves `result`, `to_acc`, `op_known` and `div_zero` unchanged.
- R3: Opcodes 06h, 09h, A4h and A6h give a+b. Opcodes 1Ah, 20h, A5h and A7h give a-b. Opcodes 19h and 1Eh give a*b. Each of these keeps only the low 8 bits of the answer.
- R4: Opcode 10h gives the bitwise complement of a. Opcodes 11h, 12h and 13h give a AND b, a OR b and a XOR b.
- R5: Opcode 14h shifts a left by b places and opcode 15h shifts a right by b places, filling with zeros. When b is 8 or more, the result is 00h.
- R6: Opcode 16h shifts a right by b places and fills with copies of bit 7. When b is 8 or more, every bit equals bit 7 of a.
- R7: Opcodes 26h and 27h rotate a left or right by (b mod 8) places. Bits that leave one end come back in at the other end.
- R8: Compares are unsigned and give 01h when true and 00h when false. Opcode 0Dh tests a<b, opcode A3h tests a>b, and opcode A0h tests a==b.
- R9: For a non-zero b, opcodes 1Dh and A2h give the unsigned quotient a/b, and opcodes 1Bh and 1Ch give the remainder a mod b.
- R10: A divide or modulo opcode with b equal to 00h gives FFh and raises `div_zero` for that result only. Every other operation gives `div_zero` low.
- R11: `to_acc` is 1 for opcodes 06h, 09h, 1Ah, 1Ch, 1Dh, 1Eh and A7h, and 0 for every other opcode.
- R12: Any opcode not named in R3 to R9 gives `op_known` low, `result` 00h, `to_acc` low and `div_zero` low. Every named opcode gives `op_known` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| opcode | input | 8 | Operation select byte |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand, also the shift or rotate amount |
| out_valid | output | 1 | Result present this cycle |
| result | output | WIDTH | Registered result byte |
| to_acc | output | 1 | Result is destined for the accumulator |
| op_known | output | 1 | Opcode names an operation of this unit |
| div_zero | output | 1 | Divide or modulo by zero occurred |

## Verification
The assertions check several behaviours on every cycle. They check the valid timing and that the outputs hold between requests. They check that compares only ever produce 00h or 01h, that a zero-divisor indication always comes with FFh and a zero divisor, and that unknown opcodes produce a clean all-zero response. The arithmetic values themselves can only be shown by the bench scenarios. The bench sweeps all 256 opcodes over a grid of operands against arithmetic reference values. That grid includes shift counts at and beyond 8, rotate counts above 7, sign-bit patterns and zero divisors.

// File: rtl/byte_alu.sv
module byte_alu #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       opcode,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic             out_valid,
  output logic [WIDTH-1:0] result,
  output logic             to_acc,
  output logic             op_known,
  output logic             div_zero
);

  localparam int CW = $clog2(WIDTH);
  localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

  localparam logic [7:0] OP_ADD_RA = 8'h06, OP_ADD_AA = 8'h09, OP_ADD_RR = 8'hA4, OP_ADD_AR = 8'hA6;
  localparam logic [7:0] OP_SUB_RA = 8'h1A, OP_SUB_RR = 8'h20, OP_SUB_AR = 8'hA5, OP_SUB_AA = 8'hA7;
  localparam logic [7:0] OP_MUL_R  = 8'h19, OP_MUL_A  = 8'h1E;
  localparam logic [7:0] OP_DIV_A  = 8'h1D, OP_DIV_R  = 8'hA2, OP_MOD_R = 8'h1B, OP_MOD_A = 8'h1C;
  localparam logic [7:0] OP_NOT = 8'h10, OP_AND = 8'h11, OP_OR = 8'h12, OP_XOR = 8'h13;
  localparam logic [7:0] OP_SHL = 8'h14, OP_SHR = 8'h15, OP_SRA = 8'h16;
  localparam logic [7:0] OP_ROL = 8'h26, OP_ROR = 8'h27;
  localparam logic [7:0] OP_LT = 8'h0D, OP_GT = 8'hA3, OP_EQ = 8'hA0;

  logic             big_cnt;
  logic [CW-1:0]    rot_cnt;
  logic [2*WIDTH-1:0] rol_w, ror_w;
  logic [WIDTH-1:0] shl_v, shr_v, sra_v, mul_v, quo_v, rem_v;
  logic             b_zero;

  assign big_cnt = (opnd_b >= WIDTH[WIDTH-1:0]) || (WIDTH >= (1 << WIDTH));
  assign rot_cnt = opnd_b[CW-1:0];
  assign rol_w   = {opnd_a, opnd_a} << rot_cnt;
  assign ror_w   = {opnd_a, opnd_a} >> rot_cnt;
  assign shl_v   = big_cnt ? '0 : opnd_a << opnd_b;
  assign shr_v   = big_cnt ? '0 : opnd_a >> opnd_b;
  assign sra_v   = big_cnt ? {WIDTH{opnd_a[WIDTH-1]}} : WIDTH'($signed(opnd_a) >>> opnd_b);
  assign mul_v   = WIDTH'(opnd_a * opnd_b);
  assign b_zero  = (opnd_b == '0);
  assign quo_v   = b_zero ? ONES : opnd_a / opnd_b;
  assign rem_v   = b_zero ? ONES : opnd_a % opnd_b;

  logic [WIDTH-1:0] nx_res;
  logic             nx_acc, nx_known, nx_dz;

  always_comb begin
    nx_res   = '0;
    nx_acc   = 1'b0;
    nx_known = 1'b1;
    nx_dz    = 1'b0;
    unique case (opcode)
      OP_ADD_RA, OP_ADD_AA: begin nx_res = opnd_a + opnd_b; nx_acc = 1'b1; end
      OP_ADD_RR, OP_ADD_AR: nx_res = opnd_a + opnd_b;
      OP_SUB_RA, OP_SUB_AA: begin nx_res = opnd_a - opnd_b; nx_acc = 1'b1; end
      OP_SUB_RR, OP_SUB_AR: nx_res = opnd_a - opnd_b;
      OP_MUL_R:  nx_res = mul_v;
      OP_MUL_A:  begin nx_res = mul_v; nx_acc = 1'b1; end
      OP_DIV_R:  begin nx_res = quo_v; nx_dz = b_zero; end
      OP_DIV_A:  begin nx_res = quo_v; nx_dz = b_zero; nx_acc = 1'b1; end
      OP_MOD_R:  begin nx_res = rem_v; nx_dz = b_zero; end
      OP_MOD_A:  begin nx_res = rem_v; nx_dz = b_zero; nx_acc = 1'b1; end
      OP_NOT:    nx_res = ~opnd_a;
      OP_AND:    nx_res = opnd_a & opnd_b;
      OP_OR:     nx_res = opnd_a | opnd_b;
      OP_XOR:    nx_res = opnd_a ^ opnd_b;
      OP_SHL:    nx_res = shl_v;
      OP_SHR:    nx_res = shr_v;
      OP_SRA:    nx_res = sra_v;
      OP_ROL:    nx_res = rol_w[2*WIDTH-1:WIDTH];
      OP_ROR:    nx_res = ror_w[WIDTH-1:0];
      OP_LT:     nx_res = (opnd_a < opnd_b) ? ONE : '0;
      OP_GT:     nx_res = (opnd_a > opnd_b) ? ONE : '0;
      OP_EQ:     nx_res = (opnd_a == opnd_b) ? ONE : '0;
      default:   nx_known = 1'b0;
    endcase
  end

  logic [7:0] op_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      to_acc    <= 1'b0;
      op_known  <= 1'b0;
      div_zero  <= 1'b0;
      op_q      <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result   <= nx_res;
        to_acc   <= nx_acc;
        op_known <= nx_known;
        div_zero <= nx_dz;
        op_q     <= opcode;
      end
    end
  end

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R2
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(result) && $stable(to_acc) && $stable(div_zero)); // R2
  AST_CMP_BOOL: assert property (@(posedge clk) disable iff (!rst_n) out_valid && (op_q == OP_LT || op_q == OP_GT || op_q == OP_EQ) |-> result <= ONE); // R8
  AST_DZ_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n) out_valid && div_zero |-> result == ONES && $past(opnd_b) == '0); // R10
  AST_DZ_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n) in_valid && opnd_b != '0 |=> !div_zero); // R10
  AST_UNKNOWN_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) out_valid && !op_known |-> result == '0 && !to_acc && !div_zero); // R12

endmodule

// File: tb/byte_alu_bench.sv
module byte_alu_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] opcode = '0;
  logic [7:0] opnd_a = '0;
  logic [7:0] opnd_b = '0;
  logic       out_valid, to_acc, op_known, div_zero;
  logic [7:0] result;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  byte_alu #(.WIDTH(8)) u_byte_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid), .result(result),
    .to_acc(to_acc), .op_known(op_known), .div_zero(div_zero)
  );

  function automatic int pick_a(int i);
    int t[16] = '{0, 1, 2, 3, 7, 17, 85, 100, 127, 128, 129, 170, 195, 250, 254, 255};
    return t[i];
  endfunction

  function automatic int pick_b(int i);
    int t[16] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 13, 64, 127, 128, 200, 255};
    return t[i];
  endfunction

  task automatic model(input int op, input int a, input int b,
                       output int r, output bit acc, output bit kn, output bit dz, output string tag);
    int sa, k;
    r = 0; acc = 0; kn = 1; dz = 0; tag = "R12";
    case (op)
      'h06, 'h09: begin r = (a + b) % 256; acc = 1; tag = "R3"; end
      'hA4, 'hA6: begin r = (a + b) % 256; tag = "R3"; end
      'h1A, 'hA7: begin r = (a - b + 256) % 256; acc = 1; tag = "R3"; end
      'h20, 'hA5: begin r = (a - b + 256) % 256; tag = "R3"; end
      'h19: begin r = (a * b) % 256; tag = "R3"; end
      'h1E: begin r = (a * b) % 256; acc = 1; tag = "R3"; end
      'h10: begin r = 255 - a; tag = "R4"; end
      'h11: begin r = a & b; tag = "R4"; end
      'h12: begin r = a | b; tag = "R4"; end
      'h13: begin r = a ^ b; tag = "R4"; end
      'h14: begin r = (b >= 8) ? 0 : (a * (2 ** b)) % 256; tag = "R5"; end
      'h15: begin r = (b >= 8) ? 0 : a / (2 ** b); tag = "R5"; end
      'h16: begin
        sa = (a >= 128) ? a - 256 : a;
        if (b >= 8) r = (a >= 128) ? 255 : 0;
        else r = (sa >>> b) & 255;
        tag = "R6";
      end
      'h26: begin k = b % 8; r = ((a * (2 ** k)) + a / (2 ** (8 - k))) % 256; tag = "R7"; end
      'h27: begin k = b % 8; r = (a / (2 ** k) + a * (2 ** (8 - k))) % 256; tag = "R7"; end
      'h0D: begin r = (a < b) ? 1 : 0; tag = "R8"; end
      'hA3: begin r = (a > b) ? 1 : 0; tag = "R8"; end
      'hA0: begin r = (a == b) ? 1 : 0; tag = "R8"; end
      'h1D, 'hA2, 'h1B, 'h1C: begin
        acc = (op == 'h1D || op == 'h1C);
        if (b == 0) begin r = 255; dz = 1; tag = "R10"; end
        else begin r = (op == 'h1D || op == 'hA2) ? a / b : a % b; tag = "R9"; end
      end
      default: kn = 0;
    endcase
    if (op == 'h06 || op == 'h09 || op == 'h1A || op == 'h1C || op == 'h1D || op == 'h1E || op == 'hA7)
      if (!acc) tag = "R11";
  endtask

  task automatic check(input string tag, input int er, input bit eacc, input bit ekn, input bit edz, input bit evld);
    n_cmp++;
    if (result !== er[7:0] || to_acc !== eacc || op_known !== ekn || div_zero !== edz || out_valid !== evld) begin
      n_bad++;
      $display("FAIL %s: got res=%02h acc=%0b kn=%0b dz=%0b vld=%0b, expected res=%02h acc=%0b kn=%0b dz=%0b vld=%0b",
               tag, result, to_acc, op_known, div_zero, out_valid, er[7:0], eacc, ekn, edz, evld);
    end
  endtask

  initial begin
    int pr; bit pacc, pkn, pdz; string ptag;
    bit have = 0;
    repeat (3) @(negedge clk);
    check("R1", 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 0, 0, 0, 0, 0);
    for (int op = 0; op < 256; op++) begin
      for (int ia = 0; ia < 16; ia++) begin
        for (int ib = 0; ib < 16; ib++) begin
          int r; bit acc, kn, dz; string tag;
          if (have) check(ptag, pr, pacc, pkn, pdz, 1);
          opcode = op[7:0]; opnd_a = pick_a(ia); opnd_b = pick_b(ib); in_valid = 1'b1;
          model(op, pick_a(ia), pick_b(ib), r, acc, kn, dz, tag);
          pr = r; pacc = acc; pkn = kn; pdz = dz; ptag = tag; have = 1;
          @(negedge clk);
        end
      end
    end
    check(ptag, pr, pacc, pkn, pdz, 1);
    opcode = 8'h1D; opnd_a = 8'h40; opnd_b = 8'h00; in_valid = 1'b1;
    @(negedge clk);
    check("R10", 255, 1, 1, 1, 1);
    in_valid = 1'b0; opcode = 8'h11; opnd_a = 8'h0F; opnd_b = 8'h03;
    @(negedge clk);
    check("R2", 255, 1, 1, 1, 0);
    @(negedge clk);
    check("R2", 255, 1, 1, 1, 0);
    in_valid = 1'b1;
    @(negedge clk);
    check("R10", 3, 0, 1, 0, 1);
    in_valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule